// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between peripherals and memory without the CPU touching each unit. Software sets up a channel with a 16-bit address, a 16-bit count, an 8-bit page that widens the memory address to 24 bits, and a transfer direction. It then issues a start command. From then on, the peripheral paces the transfer. Each assertion of the channel's request line earns one acknowledge, which is held until the memory bus grants the cycle. While the acknowledge is high, the peripheral and memory exchange one unit directly, and the controller only supplies the address and direction.

After every unit the channel's address steps up by one and its count steps down by one. The unit moved while the count reads zero is the last one, so a count of N moves N+1 units. At that point the channel goes idle and latches a terminal-count status bit. The interrupt output reflects the latched bits of the channels that are not masked. Reading the status register clears the latched bits. One channel number, chosen by a parameter, is reserved for cascading and never moves data.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, all acknowledges, the memory request and the interrupt are low, every channel is idle, the status reads 0 and the mask reads all ones.
- R2: Channel c's registers sit at register address c*4+k. For k=0 the register is the address, k=1 the count, k=2 the page (low 8 bits) and k=3 the mode. Address 16 is the status and address 17 is the mask. Written values read back one cycle after the read strobe.
- R3: A channel moves nothing until software writes its mode register with bit 1 (start) set. A request held before that gets no acknowledge.
- R4: Only one acknowledge is high at a time, and it is high only together with the memory request. The memory address is {page, address}, and the memory write flag equals mode bit 0 (1 = write to memory). The address, the flag and the acknowledge stay fixed until the memory grant.
- R5: Each granted unit adds one to the 16-bit address (wrapping from FFFF to 0000 with the page unchanged) and subtracts one from the count. Count N moves exactly N+1 units, after which the count reads FFFF and mode bit 1 (busy) reads 0.
- R6: When several enabled channels request at once, the lowest channel number is served first, and the choice is made again after every unit.
- R7: The cascade channel (default 3) never raises its acknowledge, and a start written to it leaves it idle.
- R8: A set mask bit stops its channel from being served. Clearing the bit lets a started, requesting channel proceed.
- R9: Status bit c latches when channel c finishes and clears when the status register is read.
- R10: The interrupt is high, one cycle after the status or mask changes, when any latched status bit belongs to an unmasked channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| drq | input | 4 | Per-channel peripheral request |
| dack | output | 4 | Per-channel acknowledge |
| mem_req | output | 1 | Memory bus cycle request |
| mem_gnt | input | 1 | Memory bus grant; a unit completes on a clock with mem_req and mem_gnt high |
| mem_addr | output | 24 | Memory address {page, address} |
| mem_we | output | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets several corner cases and the failure each would expose:

- **Address wrap.** An address of FFFF must wrap to 0000 on the same page. A design that carried into the page would emit a wrong 24-bit address on the second unit.
- **Off-by-one count.** A count that stopped at N units, not N+1, would leave the scoreboard holding an expected unit.
- **Priority.** Three channels request in the same cycle. An arbiter that picked the highest number, or locked onto one channel, would produce units out of order.
- **Held requests.** Requests are held before start, while masked and on the cascade channel. A design that leaked any of these would produce an unexpected unit.
- **Interrupt gating.** The mask is toggled while a status bit is latched. A wrong gating of the interrupt shows up as an interrupt that ignores the mask.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic {ENG_IDLE = 1'b0, ENG_XFER = 1'b1} eng_state_e;

  // channel register offsets (low two address bits)
  localparam logic [1:0] OFS_ADDR  = 2'd0;
  localparam logic [1:0] OFS_COUNT = 2'd1;
  localparam logic [1:0] OFS_PAGE  = 2'd2;
  localparam logic [1:0] OFS_MODE  = 2'd3;

  // global register offsets
  localparam logic [1:0] GOFS_STATUS = 2'd0;
  localparam logic [1:0] GOFS_MASK   = 2'd1;

  localparam int MODE_DIR_BIT  = 0;
  localparam int MODE_GO_BIT   = 1;
  localparam int MODE_BUSY_BIT = 1;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW       = 16,
  parameter int PW       = 8,
  parameter int DW       = 16,
  parameter bit NO_START = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_count,
  input  logic          wr_page,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] count_q,
  output logic [PW-1:0] page_q,
  output logic          dir_q,
  output logic          busy_q,
  output logic          last
);
  assign last = (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      count_q <= '0;
      page_q  <= '0;
      dir_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (wr_addr)       addr_q <= wdata[AW-1:0];
      else if (step)     addr_q <= addr_q + AW'(1);

      if (wr_count)      count_q <= wdata[AW-1:0];
      else if (step)     count_q <= count_q - AW'(1);

      if (wr_page)       page_q <= wdata[PW-1:0];
      if (wr_mode)       dir_q  <= wdata[MODE_DIR_BIT];

      // a start on the reserved channel never arms it
      if (wr_mode && wdata[MODE_GO_BIT] && !NO_START) busy_q <= 1'b1;
      else if (step && last)                          busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma4_prio_arb.sv
module dma4_prio_arb #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // scan from the top so the lowest requesting index is the last to win
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter  int NCH        = 4,
  parameter  int AW         = 16,
  parameter  int PW         = 8,
  parameter  int DW         = 16,
  parameter  int CASCADE_CH = 3,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW        = CHW + 3,
  localparam int MW         = PW + AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic           reg_re,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] drq,
  output logic [NCH-1:0] dack,
  output logic           mem_req,
  input  logic           mem_gnt,
  output logic [MW-1:0]  mem_addr,
  output logic           mem_we,
  output logic           irq
);
  localparam logic [NCH-1:0] CASC_BIT = NCH'(1) << CASCADE_CH;

  // register decode
  logic           is_glob;
  logic [CHW-1:0] sel_ch;
  logic [1:0]     sel_ofs;
  assign is_glob = reg_addr[RAW-1];
  assign sel_ch  = reg_addr[CHW+1:2];
  assign sel_ofs = reg_addr[1:0];

  logic rd_status, wr_mask;
  assign rd_status = reg_re & is_glob & (sel_ofs == GOFS_STATUS);
  assign wr_mask   = reg_we & is_glob & (sel_ofs == GOFS_MASK);

  // channel state
  logic [AW-1:0]  ch_addr  [NCH];
  logic [AW-1:0]  ch_count [NCH];
  logic [PW-1:0]  ch_page  [NCH];
  logic [NCH-1:0] ch_dir, ch_busy, ch_last, step;
  logic [NCH-1:0] tc_q, mask_q;

  eng_state_e     st_q;
  logic [CHW-1:0] cur_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit     = reg_we & ~is_glob & (sel_ch == CHW'(g));
    assign step[g] = (st_q == ENG_XFER) & mem_gnt & (cur_q == CHW'(g));

    dma4_chan #(
      .AW(AW), .PW(PW), .DW(DW), .NO_START(g == CASCADE_CH)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_addr (hit & (sel_ofs == OFS_ADDR)),
      .wr_count(hit & (sel_ofs == OFS_COUNT)),
      .wr_page (hit & (sel_ofs == OFS_PAGE)),
      .wr_mode (hit & (sel_ofs == OFS_MODE)),
      .wdata   (reg_wdata),
      .step    (step[g]),
      .addr_q  (ch_addr[g]),
      .count_q (ch_count[g]),
      .page_q  (ch_page[g]),
      .dir_q   (ch_dir[g]),
      .busy_q  (ch_busy[g]),
      .last    (ch_last[g])
    );
  end

  // arbitration over started, unmasked, requesting channels
  logic [NCH-1:0] elig, arb_gnt;
  logic [CHW-1:0] arb_idx;
  logic           arb_any;
  assign elig = drq & ch_busy & ~mask_q & ~CASC_BIT;

  dma4_prio_arb #(.N(NCH)) u_arb (
    .req(elig),
    .gnt(arb_gnt),
    .idx(arb_idx),
    .any(arb_any)
  );

  // transfer engine: one unit per grant
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ENG_IDLE;
      cur_q    <= '0;
      dack     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_we   <= 1'b0;
    end else begin
      case (st_q)
        ENG_IDLE: if (arb_any) begin
          st_q     <= ENG_XFER;
          cur_q    <= arb_idx;
          dack     <= arb_gnt;
          mem_req  <= 1'b1;
          mem_addr <= {ch_page[arb_idx], ch_addr[arb_idx]};
          mem_we   <= ch_dir[arb_idx];
        end
        ENG_XFER: if (mem_gnt) begin
          st_q    <= ENG_IDLE;
          dack    <= '0;
          mem_req <= 1'b0;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  // terminal-count status, mask and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= '0;
      mask_q <= '1;
      irq    <= 1'b0;
    end else begin
      tc_q <= (rd_status ? '0 : tc_q) | (step & ch_last);
      if (wr_mask) mask_q <= reg_wdata[NCH-1:0];
      irq <= |(tc_q & ~mask_q);
    end
  end

  // registered read port
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (is_glob) begin
      if (sel_ofs == GOFS_STATUS)    rd_mux[NCH-1:0] = tc_q;
      else if (sel_ofs == GOFS_MASK) rd_mux[NCH-1:0] = mask_q;
    end else begin
      case (sel_ofs)
        OFS_ADDR:  rd_mux[AW-1:0] = ch_addr[sel_ch];
        OFS_COUNT: rd_mux[AW-1:0] = ch_count[sel_ch];
        OFS_PAGE:  rd_mux[PW-1:0] = ch_page[sel_ch];
        default: begin
          rd_mux[MODE_DIR_BIT]  = ch_dir[sel_ch];
          rd_mux[MODE_BUSY_BIT] = ch_busy[sel_ch];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH        = 4,
  parameter int CASCADE_CH = 3,
  parameter int MW         = 24
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] drq,
  input logic [NCH-1:0] dack,
  input logic [NCH-1:0] mask_q,
  input logic           mem_req,
  input logic           mem_gnt,
  input logic [MW-1:0]  mem_addr,
  input logic           irq
);
  // R1: outputs quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dack == '0 && !mem_req && !irq));

  // R4: at most one acknowledge
  p_dack_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));

  // R4: acknowledge only alongside a memory request
  p_dack_with_req_r4: assert property (@(posedge clk) disable iff (rst)
    (|dack) |-> mem_req);

  // R4: request, address and acknowledge hold until granted
  p_hold_till_gnt_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(dack)));

  // R7: cascade channel never acknowledged
  p_cascade_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !dack[CASCADE_CH]);

  // R8: a new acknowledge answers a request of an unmasked channel
  p_unmasked_req_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(|dack) |-> (|(dack & $past(drq & ~mask_q))));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(
  .NCH(NCH), .CASCADE_CH(CASCADE_CH), .MW(PW + AW)
) u_chk (
  .clk(clk), .rst(rst), .drq(drq), .dack(dack), .mask_q(mask_q),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .irq(irq)
);

// File: tb/dma4_ctrl_tb.sv
module dma4_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  drq = '0;
  logic [3:0]  dack;
  logic        mem_req, mem_we, irq;
  logic        mem_gnt = 1'b1;
  logic [23:0] mem_addr;

  always #2 clk = ~clk;  // 250 MHz

  dma4_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drq(drq), .dack(dack), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_we(mem_we), .irq(irq)
  );

  typedef struct packed {
    logic [23:0] addr;
    logic        we;
    logic [1:0]  ch;
  } unit_t;

  unit_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [4:0] ra(input int c, input int k);
    return 5'(c * 4 + k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a; reg_re = 1'b1;
    @(posedge clk); #1;
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_unit(input logic [23:0] a, input logic we, input logic [1:0] c);
    unit_t u;
    u.addr = a; u.we = we; u.ch = c;
    exp_q.push_back(u);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 400) begin
      @(posedge clk); #1;
      n++;
    end
    chk({tag, " pending units"}, exp_q.size(), 0);
    idle(3);
  endtask

  // monitor: each granted unit is compared with the next expected one
  always @(negedge clk) begin
    if (!rst && mem_req && mem_gnt) begin
      if (exp_q.size() == 0) begin
        chk("R3/R8 unexpected unit", {dack, mem_we, 3'b0, mem_addr}, 32'h0);
      end else begin
        unit_t u;
        u = exp_q.pop_front();
        chk("R4 mem_addr", mem_addr, u.addr);
        chk("R4 mem_we", mem_we, u.we);
        chk("R6 dack channel", dack, 4'b0001 << u.ch);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1..R10 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    chk("R1 dack", dack, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 irq", irq, 0);
    rd(5'd17, d); chk("R1 mask", d, 16'h000F);
    rd(5'd16, d); chk("R1 status", d, 0);
    rd(ra(1, 3), d); chk("R1 busy", d, 0);

    // R2 programming and readback; R3 nothing before start
    wr(5'd17, 16'h000D);
    wr(ra(1, 0), 16'h1234);
    wr(ra(1, 1), 16'h0002);
    wr(ra(1, 2), 16'h005A);
    wr(ra(1, 3), 16'h0001);
    rd(ra(1, 0), d); chk("R2 addr", d, 16'h1234);
    rd(ra(1, 1), d); chk("R2 count", d, 16'h0002);
    rd(ra(1, 2), d); chk("R2 page", d, 16'h005A);
    rd(ra(1, 3), d); chk("R2 mode", d, 16'h0001);
    drq[1] = 1'b1;
    idle(6);
    chk("R3 no dack before start", dack, 0);
    chk("R3 no mem_req before start", mem_req, 0);

    // R5 count 2 moves 3 units
    expect_unit(24'h5A1234, 1'b1, 2'd1);
    expect_unit(24'h5A1235, 1'b1, 2'd1);
    expect_unit(24'h5A1236, 1'b1, 2'd1);
    wr(ra(1, 3), 16'h0003);
    drain("R5");
    rd(ra(1, 0), d); chk("R5 final addr", d, 16'h1237);
    rd(ra(1, 1), d); chk("R5 final count", d, 16'hFFFF);
    rd(ra(1, 3), d); chk("R5 idle after last", d, 16'h0001);
    chk("R10 irq on done", irq, 1);
    rd(5'd16, d); chk("R9 status latched", d, 16'h0002);
    rd(5'd16, d); chk("R9 status cleared", d, 0);
    idle(2);
    chk("R10 irq after clear", irq, 0);
    drq[1] = 1'b0;

    // R5 address wrap keeps page
    wr(5'd17, 16'h000C);
    wr(ra(0, 0), 16'hFFFF);
    wr(ra(0, 1), 16'h0001);
    wr(ra(0, 2), 16'h0003);
    expect_unit(24'h03FFFF, 1'b0, 2'd0);
    expect_unit(24'h030000, 1'b0, 2'd0);
    drq[0] = 1'b1;
    wr(ra(0, 3), 16'h0002);
    drain("R5 wrap");
    rd(ra(0, 0), d); chk("R5 wrapped addr", d, 16'h0001);
    rd(ra(0, 2), d); chk("R5 page unchanged", d, 16'h0003);
    drq[0] = 1'b0;
    rd(5'd16, d); chk("R9 ch0 status", d, 16'h0001);

    // R6 fixed priority, lowest first
    wr(5'd17, 16'h0008);
    wr(ra(0, 0), 16'h0100); wr(ra(0, 1), 16'h0000); wr(ra(0, 2), 16'h0001);
    wr(ra(1, 0), 16'h0200); wr(ra(1, 1), 16'h0000); wr(ra(1, 2), 16'h0002);
    wr(ra(2, 0), 16'h0300); wr(ra(2, 1), 16'h0001); wr(ra(2, 2), 16'h0004);
    wr(ra(0, 3), 16'h0003);
    wr(ra(1, 3), 16'h0002);
    wr(ra(2, 3), 16'h0003);
    expect_unit(24'h010100, 1'b1, 2'd0);
    expect_unit(24'h020200, 1'b0, 2'd1);
    expect_unit(24'h040300, 1'b1, 2'd2);
    expect_unit(24'h040301, 1'b1, 2'd2);
    drq = 4'b0111;
    drain("R6");
    drq = 4'b0000;
    rd(5'd16, d); chk("R6 all three done", d, 16'h0007);

    // R8 mask holds a started channel; R10 interrupt gating
    wr(5'd17, 16'h000F);
    wr(ra(1, 0), 16'h0040); wr(ra(1, 1), 16'h0000); wr(ra(1, 2), 16'h0000);
    wr(ra(1, 3), 16'h0002);
    drq[1] = 1'b1;
    idle(8);
    chk("R8 masked no dack", dack, 0);
    expect_unit(24'h000040, 1'b0, 2'd1);
    wr(5'd17, 16'h000D);
    drain("R8");
    chk("R10 irq unmasked", irq, 1);
    wr(5'd17, 16'h000F);
    idle(2);
    chk("R10 irq masked", irq, 0);
    wr(5'd17, 16'h000D);
    idle(2);
    chk("R10 irq unmasked again", irq, 1);
    rd(5'd16, d); chk("R9 status ch1", d, 16'h0002);
    idle(2);
    chk("R10 irq cleared", irq, 0);
    drq[1] = 1'b0;

    // R7 cascade channel ignores start
    wr(5'd17, 16'h0000);
    wr(ra(3, 0), 16'h0010); wr(ra(3, 1), 16'h0000);
    wr(ra(3, 3), 16'h0003);
    drq[3] = 1'b1;
    idle(8);
    chk("R7 cascade no dack", dack, 0);
    chk("R7 cascade no mem_req", mem_req, 0);
    rd(ra(3, 3), d); chk("R7 cascade not busy", d & 16'h0002, 0);
    rd(5'd16, d); chk("R7 cascade no status", d, 0);
    drq[3] = 1'b0;

    idle(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule